// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides when the chip gives its external bus to another master and when it takes it back. An outside master asks for the bus with an asynchronous hold request. The arbiter first stops the local bus cycle controller from starting new cycles. It waits for the running cycle to finish, then acknowledges the hold and floats the chip's bus and control outputs. While the bus is away, the arbiter raises a bus request whenever an internal access is waiting, so the outside master knows the chip needs the bus back.

Only the outside master releasing its hold starts the regain. A pending bus request never ends the grant by itself, and a release that arrives with no request raised is handled the same way. On regain the acknowledge drops first. The drivers are re-enabled a programmable number of clocks later, and new internal cycles stay blocked until the drivers are back.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset, holdAck, busReq, floatEn and blockCycles are all low.
- R2: holdReq passes through a two-stage synchronizer. blockCycles goes high at the third rising clock edge after holdReq goes high.
- R3: holdAck goes high at the first rising edge, from the fourth edge after holdReq rises onward, at which cycleBusy is sampled low. It never rises while a cycle is running.
- R4: floatEn goes high at the same edge as holdAck and stays high for the whole time holdAck is high.
- R5: busReq is high only while holdAck is high. It equals accessPending as sampled at the previous edge. When the bus is not granted, accessPending has no effect on busReq.
- R6: A raised busReq does not end the grant. holdAck stays high until holdReq is released.
- R7: After holdReq goes low during a grant, holdAck and busReq drop at the third rising edge. floatEn drops REGAIN_GAP edges later (default 1), so the acknowledge drops before the drivers return.
- R8: blockCycles stays high from the start of draining until the edge at which floatEn drops. It never is low while floatEn is high.
- R9: If holdReq is withdrawn before the grant, no acknowledge is given, and blockCycles drops at the third rising edge after the withdrawal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| holdReq | input | 1 | Asynchronous bus hold request from the outside master, active high |
| accessPending | input | 1 | An internal access needs the external bus |
| cycleBusy | input | 1 | The bus cycle controller is running a cycle |
| holdAck | output | 1 | Bus handed to the outside master |
| busReq | output | 1 | Request to the outside master to give the bus back |
| floatEn | output | 1 | Float the bus and control outputs (weak high on selects) |
| blockCycles | output | 1 | Forbid the cycle controller from starting new cycles |

## Verification
The grant is swept over the length of the running cycle at the moment the hold arrives, from zero to eight clocks. Every sampled clock of each run is compared with the edge at which the acknowledge must appear, so both an early grant and a late one are caught. Release is tried with and without a raised bus request, which shows that only the hold release starts the regain and that the one-clock gap between acknowledge and drivers is present in both cases. A hold withdrawn during a long cycle, and access requests made outside a grant, show that no acknowledge or request leaks out when it should not.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_GRANT  = 2'd2,
    ST_REGAIN = 2'd3
  } arbState_t;

  typedef struct packed {
    logic setBlock;
    logic clrBlock;
    logic setGrant;
    logic endGrant;
    logic clrFloat;
    logic loadGap;
  } arbStrobe_t;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[gi] <= 1'b0;
          else       chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdSync,
  input  logic       cycleBusy,
  input  logic       gapDone,
  output arbStrobe_t strobe,
  output arbState_t  stateQ
);
  arbState_t stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_RUN: begin
        if (holdSync) begin
          stateD          = ST_DRAIN;
          strobe.setBlock = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!holdSync) begin
          stateD          = ST_RUN;
          strobe.clrBlock = 1'b1;
        end else if (!cycleBusy) begin
          stateD          = ST_GRANT;
          strobe.setGrant = 1'b1;
        end
      end
      ST_GRANT: begin
        if (!holdSync) begin
          stateD          = ST_REGAIN;
          strobe.endGrant = 1'b1;
          strobe.loadGap  = 1'b1;
        end
      end
      ST_REGAIN: begin
        if (gapDone) begin
          stateD          = ST_RUN;
          strobe.clrFloat = 1'b1;
          strobe.clrBlock = 1'b1;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  // R3
  grant_needs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_GRANT && $past(stateQ) == ST_DRAIN) |-> $past(!cycleBusy));

  // R9
  drain_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DRAIN && !holdSync) |=> stateQ == ST_RUN);
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int REGAIN_GAP = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  arbStrobe_t strobe,
  input  logic       accessPending,
  output logic       gapDone,
  output logic       ackQ,
  output logic       floatQ,
  output logic       busReqQ,
  output logic       blockQ
);
  localparam int GAP_W = (REGAIN_GAP < 2) ? 1 : $clog2(REGAIN_GAP);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(REGAIN_GAP - 1);

  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ    <= 1'b0;
      floatQ  <= 1'b0;
      busReqQ <= 1'b0;
      blockQ  <= 1'b0;
      gapCnt  <= '0;
    end else begin
      if (strobe.setGrant)      ackQ <= 1'b1;
      else if (strobe.endGrant) ackQ <= 1'b0;

      if (strobe.setGrant)      floatQ <= 1'b1;
      else if (strobe.clrFloat) floatQ <= 1'b0;

      if (strobe.setBlock)      blockQ <= 1'b1;
      else if (strobe.clrBlock) blockQ <= 1'b0;

      if (strobe.endGrant || !ackQ) busReqQ <= 1'b0;
      else                          busReqQ <= accessPending;

      if (strobe.loadGap)   gapCnt <= GAP_LOAD;
      else if (gapCnt != 0) gapCnt <= gapCnt - 1'b1;
    end
  end

  assign gapDone = (gapCnt == '0);

  // R4
  float_covers_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> floatQ);

  // R5
  req_only_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReqQ |-> ackQ);

  // R7
  ack_before_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(floatQ) |-> (!ackQ && $past(!ackQ)));

  // R8
  block_covers_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    floatQ |-> blockQ);
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REGAIN_GAP  = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic holdReq,
  input  logic accessPending,
  input  logic cycleBusy,
  output logic holdAck,
  output logic busReq,
  output logic floatEn,
  output logic blockCycles
);
  logic       holdSync;
  logic       gapDone;
  arbStrobe_t strobe;
  arbState_t  stateQ;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(holdReq), .syncOut(holdSync)
  );

  arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .holdSync(holdSync), .cycleBusy(cycleBusy),
    .gapDone(gapDone), .strobe(strobe), .stateQ(stateQ)
  );

  arb_datapath #(.REGAIN_GAP(REGAIN_GAP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accessPending(accessPending),
    .gapDone(gapDone), .ackQ(holdAck), .floatQ(floatEn),
    .busReqQ(busReq), .blockQ(blockCycles)
  );

  // R3
  ack_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> $past(!cycleBusy));

  // R6
  ack_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && holdSync) |=> holdAck);
endmodule

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdReq = 1'b0;
  logic accessPending = 1'b0;
  logic cycleBusy = 1'b0;
  logic holdAck, busReq, floatEn, blockCycles;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter uut (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .accessPending(accessPending),
    .cycleBusy(cycleBusy), .holdAck(holdAck), .busReq(busReq),
    .floatEn(floatEn), .blockCycles(blockCycles)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // bring the arbiter into grant with no running cycle (grant at edge 4)
  task automatic grantIdle();
    holdReq = 1'b1;
    cycleBusy = 1'b0;
    repeat (4) step();
  endtask

  // release and check regain timing: ack drops at edge 3, float at edge 4
  task automatic releaseCheck();
    holdReq = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      step();
      check("R7 ack", holdAck, k < 3);
      check("R7 busReq", busReq, (k < 3) ? busReq : 1'b0);
      check("R7 float", floatEn, k < 4);
      check("R8 block", blockCycles, k < 4);
    end
  endtask

  initial begin
    repeat (3) step();
    check("R1 ack", holdAck, 1'b0);
    check("R1 busReq", busReq, 1'b0);
    check("R1 float", floatEn, 1'b0);
    check("R1 block", blockCycles, 1'b0);
    rstN = 1'b1;
    step();

    // R5: access requests outside a grant have no effect
    accessPending = 1'b1;
    repeat (3) begin
      step();
      check("R5 idle busReq", busReq, 1'b0);
    end
    accessPending = 1'b0;

    // R2 R3 R4: sweep the running-cycle length at hold arrival
    for (int b = 0; b <= 8; b++) begin
      int grantEdge;
      grantEdge = (b + 1 > 4) ? b + 1 : 4;
      holdReq = 1'b1;
      cycleBusy = (b > 0);
      for (int k = 1; k <= grantEdge + 2; k++) begin
        step();
        if (k == b) cycleBusy = 1'b0;
        check("R2 block", blockCycles, k >= 3);
        check("R3 ack", holdAck, k >= grantEdge);
        check("R4 float", floatEn, k >= grantEdge);
        check("R5 busReq", busReq, 1'b0);
      end
      releaseCheck();
      step();
    end

    // R5 R6: request raised during grant does not end it
    grantIdle();
    check("R3 idle grant", holdAck, 1'b1);
    accessPending = 1'b1;
    step();
    check("R5 req up", busReq, 1'b1);
    repeat (6) begin
      step();
      check("R6 ack kept", holdAck, 1'b1);
      check("R5 req kept", busReq, 1'b1);
    end
    accessPending = 1'b0;
    step();
    check("R5 req down", busReq, 1'b0);
    accessPending = 1'b1;
    step();
    check("R5 req again", busReq, 1'b1);
    releaseCheck();
    check("R5 after regain", busReq, 1'b0);
    accessPending = 1'b0;
    step();

    // R9: hold withdrawn while a long cycle runs
    holdReq = 1'b1;
    cycleBusy = 1'b1;
    repeat (5) step();
    check("R9 draining", blockCycles, 1'b1);
    holdReq = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      step();
      check("R9 no ack", holdAck, 1'b0);
      check("R9 no float", floatEn, 1'b0);
      check("R9 block", blockCycles, k < 3);
    end
    cycleBusy = 1'b0;
    repeat (3) step();
    check("R9 stays idle", holdAck, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule